// File: doc/BRIEF.md
# Packed BCD Decimal Adjust Unit

This block takes the 8-bit result of a binary addition of two packed-BCD bytes and turns it back into a valid two-digit packed-BCD value. Alongside the raw byte it receives the carry and half-carry flags that the adder produced. It returns the corrected byte, a new carry, a new half-carry, and zero, sign and even-parity flags taken from the corrected byte.

The correction is purely combinational. A parameter selects whether an output register stage is placed after it. With the stage present, results appear one clock after the inputs and reset clears the stage. The adder in front of the block and any instruction decode are outside it. A typical use: the adder produces 6Dh from 55h + 18h with both flags clear, and the unit returns 73h.

Top module: `bcd_dadj`

## Requirements
- R1: When the low nibble of `acc_i` exceeds 9, 06h is added to the whole byte, and any carry out of bit 3 moves into the high nibble (6Dh gives 73h).
- R2: When `af_i` is 1, 06h is added even if the low nibble is 9 or less (12h with `af_i`=1 gives 18h).
- R3: `af_o` is 1 exactly when the 06h correction of R1 or R2 was applied, and 0 otherwise.
- R4: When `cf_i` is 1 or `acc_i` is above 99h, 60h is also added (modulo 256) and `cf_o` is 1. Otherwise `cf_o` is 0.
- R5: `zf_o` is 1 exactly when the corrected byte is 00h.
- R6: `sf_o` equals bit 7 of the corrected byte.
- R7: `pf_o` is 1 when the corrected byte holds an even number of 1 bits (00h gives 1), and 0 otherwise.
- R8: With `REG_OUT`=1, every output takes its new value at the first rising clock edge after the inputs change. While `rst_ni` is low, every output is 0.
- R9: An input with both nibbles at 9 or less and both incoming flags clear passes through unchanged, with `cf_o`=0 and `af_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 8 | Binary sum to be corrected |
| cf_i | input | 1 | Carry out of the preceding add |
| af_i | input | 1 | Carry out of bit 3 of the preceding add |
| res_o | output | 8 | Corrected packed-BCD byte |
| cf_o | output | 1 | Decimal carry out |
| af_o | output | 1 | Low correction applied |
| zf_o | output | 1 | Corrected byte is zero |
| sf_o | output | 1 | Bit 7 of the corrected byte |
| pf_o | output | 1 | Even parity of the corrected byte |

## Verification
The vectors cover five groups of input:
- **Low digit out of range only:** proves that the 06h step alone is taken.
- **Half-carry with a legal low digit:** separates the flag-driven path from the range check.
- **Carry-in with a legal high digit, and a byte above 99h with both flags clear:** separate the two triggers of the 60h step.
- **Legal BCD with both flags clear:** shows that nothing is altered.

Bytes such as 9Ah, 9Fh and FFh sit on the boundary. In these, the low correction pushes the high digit over 9 or wraps the byte, so they check that the high decision is made on the original value and that the result reaches zero with its flags. A directed step samples the output before and after a clock edge to confirm the register stage and its reset value.

// File: rtl/bcd_dadj_pkg.sv
package bcd_dadj_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NIB_W  = DATA_W / 2;
  localparam logic [NIB_W-1:0]  DIGIT_MAX = NIB_W'(9);
  localparam logic [DATA_W-1:0] BYTE_MAX  = DATA_W'(8'h99);
  localparam logic [DATA_W-1:0] LO_FIX    = DATA_W'(8'h06);
  localparam logic [DATA_W-1:0] HI_FIX    = DATA_W'(8'h60);

  typedef struct packed {
    logic [DATA_W-1:0] res;
    logic              cf;
    logic              af;
    logic              zf;
    logic              sf;
    logic              pf;
  } dadj_out_t;
endpackage

// File: rtl/bcd_lo_fix.sv
module bcd_lo_fix
  import bcd_dadj_pkg::*;
(
  input  logic [DATA_W-1:0] acc_i,
  input  logic              af_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              lo_hit_o
);
  always_comb begin
    lo_hit_o = (acc_i[NIB_W-1:0] > DIGIT_MAX) || af_i;
    // full-width add so the nibble carry ripples upward
    sum_o    = lo_hit_o ? (acc_i + LO_FIX) : acc_i;
  end
endmodule

// File: rtl/bcd_hi_fix.sv
module bcd_hi_fix
  import bcd_dadj_pkg::*;
(
  input  logic [DATA_W-1:0] orig_i,
  input  logic [DATA_W-1:0] sum_i,
  input  logic              cf_i,
  output logic [DATA_W-1:0] res_o,
  output logic              hi_hit_o
);
  always_comb begin
    // decided on the original byte, not the low-corrected one
    hi_hit_o = cf_i || (orig_i > BYTE_MAX);
    res_o    = hi_hit_o ? (sum_i + HI_FIX) : sum_i;
  end
endmodule

// File: rtl/bcd_flag_gen.sv
module bcd_flag_gen
  import bcd_dadj_pkg::*;
(
  input  logic [DATA_W-1:0] res_i,
  output logic              zf_o,
  output logic              sf_o,
  output logic              pf_o
);
  always_comb begin
    zf_o = (res_i == '0);
    sf_o = res_i[DATA_W-1];
    pf_o = ~(^res_i);
  end
endmodule

// File: rtl/bcd_dadj.sv
module bcd_dadj
  import bcd_dadj_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              cf_i,
  input  logic              af_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cf_o,
  output logic              af_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              pf_o
);
  logic [DATA_W-1:0] lo_sum;
  logic              lo_hit;
  logic [DATA_W-1:0] hi_res;
  logic              hi_hit;
  logic              flg_z, flg_s, flg_p;
  dadj_out_t         nxt, cur;

  bcd_lo_fix u_lo (
    .acc_i   (acc_i),
    .af_i    (af_i),
    .sum_o   (lo_sum),
    .lo_hit_o(lo_hit)
  );

  bcd_hi_fix u_hi (
    .orig_i  (acc_i),
    .sum_i   (lo_sum),
    .cf_i    (cf_i),
    .res_o   (hi_res),
    .hi_hit_o(hi_hit)
  );

  bcd_flag_gen u_flg (
    .res_i(hi_res),
    .zf_o (flg_z),
    .sf_o (flg_s),
    .pf_o (flg_p)
  );

  always_comb begin
    nxt.res = hi_res;
    nxt.cf  = hi_hit;
    nxt.af  = lo_hit;
    nxt.zf  = flg_z;
    nxt.sf  = flg_s;
    nxt.pf  = flg_p;
  end

  generate
    if (REG_OUT) begin : g_reg
      dadj_out_t out_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= nxt;
      end
      assign cur = out_q;
    end else begin : g_comb
      assign cur = nxt;
    end
  endgenerate

  assign res_o = cur.res;
  assign cf_o  = cur.cf;
  assign af_o  = cur.af;
  assign zf_o  = cur.zf;
  assign sf_o  = cur.sf;
  assign pf_o  = cur.pf;

  assert_lo_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i[NIB_W-1:0] > DIGIT_MAX) |-> (lo_sum == acc_i + LO_FIX));
  assert_af_forces_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    af_i |-> nxt.af);
  assert_cf_in_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cf_i |-> nxt.cf);
  assert_zero_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nxt.zf |-> (hi_res == '0));
  assert_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i[NIB_W-1:0] <= DIGIT_MAX && acc_i[DATA_W-1:NIB_W] <= DIGIT_MAX
     && !cf_i && !af_i) |-> (hi_res == acc_i && !nxt.cf && !nxt.af));
endmodule

// File: tb/tb_bcd_dadj.sv
module tb_bcd_dadj;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] acc_i = '0;
  logic       cf_i = 1'b0, af_i = 1'b0;
  logic [7:0] res_o;
  logic       cf_o, af_o, zf_o, sf_o, pf_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  bcd_dadj #(.REG_OUT(1'b1)) dut (
    .clk_i, .rst_ni, .acc_i, .cf_i, .af_i,
    .res_o, .cf_o, .af_o, .zf_o, .sf_o, .pf_o
  );

  // {acc, cf, af, res, cf_o, af_o, zf, sf, pf}
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {8'h6D,1'b0,1'b0, 8'h73,1'b0,1'b1,1'b0,1'b0,1'b0}, // R1
    {8'h45,1'b0,1'b0, 8'h45,1'b0,1'b0,1'b0,1'b0,1'b0}, // R9
    {8'h9A,1'b0,1'b0, 8'h00,1'b1,1'b1,1'b1,1'b0,1'b1}, // R4 R5
    {8'h00,1'b0,1'b0, 8'h00,1'b0,1'b0,1'b1,1'b0,1'b1}, // R9 R7
    {8'h12,1'b0,1'b1, 8'h18,1'b0,1'b1,1'b0,1'b0,1'b1}, // R2 R3
    {8'h23,1'b1,1'b0, 8'h83,1'b1,1'b0,1'b0,1'b1,1'b0}, // R4 R6
    {8'hA5,1'b0,1'b0, 8'h05,1'b1,1'b0,1'b0,1'b0,1'b1}, // R4
    {8'h99,1'b0,1'b0, 8'h99,1'b0,1'b0,1'b0,1'b1,1'b1}, // R9
    {8'hFF,1'b0,1'b0, 8'h65,1'b1,1'b1,1'b0,1'b0,1'b1}, // R1 R4
    {8'h0A,1'b1,1'b1, 8'h70,1'b1,1'b1,1'b0,1'b0,1'b0}, // R2 R4
    {8'h9F,1'b0,1'b0, 8'h05,1'b1,1'b1,1'b0,1'b0,1'b1}, // R1 R4
    {8'h3C,1'b0,1'b1, 8'h42,1'b0,1'b1,1'b0,1'b0,1'b1}  // R1 R3
  };

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] outs();
    return {res_o, cf_o, af_o, zf_o, sf_o, pf_o};
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    acc_i = 8'hFF; cf_i = 1'b1; af_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R8 reset", outs(), 13'h0);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      {acc_i, cf_i, af_i} = VEC[i][22:13];
      @(negedge clk_i);
      check($sformatf("R1-R9 vec%0d R1 R2 R3 R4 R5 R6 R7 R9", i), outs(), VEC[i][12:0]);
    end
    // R8: value held until the next rising edge
    @(negedge clk_i);
    acc_i = 8'h6D; cf_i = 1'b0; af_i = 1'b0;
    @(negedge clk_i);
    acc_i = 8'h23; cf_i = 1'b1;
    #1 check("R8 hold", outs(), {8'h73,1'b0,1'b1,1'b0,1'b0,1'b0});
    @(negedge clk_i);
    check("R8 update", outs(), {8'h83,1'b1,1'b0,1'b0,1'b1,1'b0});
    // R8: async reset clears outputs
    #3 rst_ni = 1'b0;
    #1 check("R8 async", outs(), 13'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule